// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is a 32-bit processor core that finishes one instruction per clock cycle. Within that cycle it fetches the instruction word addressed by the program counter. It then decodes the word and reads the register operands, computes through the ALU, and optionally reads or writes data memory. The result is written back to a register on the closing rising edge. The instruction subset is small: five register-register operations (add, subtract, and, or, signed set-less-than), two immediate operations (add and signed set-less-than), word load, word store and branch-if-equal.

Instruction storage and data storage are separate word-addressed arrays inside the core, so a fetch and a data access happen in the same cycle. A load port fills either array from outside. While that port is active the core is frozen: the PC holds and no register or data-memory write from execution takes place. The current PC, the fetched word and the write-back and store activity are brought out on ports so that the surrounding environment can follow execution.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 registers to 0.
- R2: When not loading and not taking a branch, the PC advances by 4 each cycle. The instruction fetched is word (PC>>2) modulo the instruction depth, and the fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm [15:0].
- R3: Opcode 0x00 with funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt into register rd.
- R4: Funct 0x2A (opcode 0x00, result into rd) and opcode 0x0A (immediate, result into rt) write 1 when the rs value is less than the second operand in two's complement, and 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate into rt.
- R6: Opcode 0x23 forms the byte address rs + sign-extended imm, reads data word (address>>2) modulo the data depth, and writes it into rt.
- R7: Opcode 0x2B writes the rt value to the data word at address rs + sign-extended imm, and writes no register.
- R8: Opcode 0x04 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended imm shifted left by 2; otherwise it is PC+4.
- R9: Register 0 always reads as 0; a write aimed at it is reported on the write-back port but has no effect.
- R10: Register and data writes take effect at the rising edge, so an instruction that reads its own destination sees the old value, and the next instruction sees the new one.
- R11: While ld_en is 1, ld_data is written at word ld_addr into instruction memory (ld_sel=0) or data memory (ld_sel=1). The PC holds, and wb_en_o and dmem_we_o stay 0.
- R12: Any other opcode, or opcode 0x00 with any other funct, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load port active; core frozen |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word being executed |
| wb_en_o | output | 1 | A register write-back occurs this cycle |
| wb_idx_o | output | 5 | Destination register of the write-back |
| wb_data_o | output | 32 | Value being written back |
| dmem_we_o | output | 1 | A store occurs this cycle |
| dmem_addr_o | output | 32 | Byte address computed by the ALU |
| dmem_wdata_o | output | 32 | Word being stored |

## Verification
The program mixes positive and negative operands, so the signed compare is told apart from an unsigned one (set-less-than on -3 versus 5), and sign extension is told apart from zero extension through negative immediates and negative load/store offsets. A store followed by a load of the same word, plus an instruction that decrements its own source register, separate old-value reads from edge-timed writes. A branch that is not taken, a forward taken branch and a backward loop branch distinguish the compare, the offset scaling and the offset sign. Writes aimed at register 0, an unknown opcode, and load-port pulses both before and during execution check that no state is touched.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    alu_imm;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_seq,
                                                  input logic [XLEN-1:0] ofs);
    return pc_seq + {ofs[XLEN-3:0], 2'b00};
  endfunction
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{reg_write: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, mem_read: 1'b0,
            mem_write: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.reg_write = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
      end
      OPC_SLTI: begin
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
        ctl.alu_op    = ALU_SLT;
      end
      OPC_LW: begin
        ctl.reg_write = 1'b1;
        ctl.alu_imm   = 1'b1;
        ctl.mem_read  = 1'b1;
      end
      OPC_SW: begin
        ctl.alu_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  always_comb begin
    if (op == ALU_SLT) begin
      AST_SLT_BIT: assert (y[W-1:1] == '0); // R4
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o,
  output logic            wb_en_o,
  output logic [RAW-1:0]  wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_seq, br_tgt, pc_next;
  logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
  logic [RAW-1:0]  wb_idx;
  logic [IAW-1:0]  fetch_idx;
  logic [DAW-1:0]  dm_idx;
  logic            alu_zero, run, rf_we, dm_we, take_br;
  ctrl_t           ctl;

  // fetch
  assign fetch_idx = pc_q[IAW+1:2];
  assign instr     = imem[fetch_idx];

  // decode and register read
  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign simm   = sext16(instr[15:0]);
  assign wb_idx = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (rf_we),
    .wa  (wb_idx),
    .wd  (wb_data)
  );

  // execute
  assign alu_b = ctl.alu_imm ? simm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op   (ctl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // memory access
  assign dm_idx   = alu_y[DAW+1:2];
  assign dm_rdata = dmem[dm_idx];
  assign wb_data  = ctl.mem_read ? dm_rdata : alu_y;

  // execution gating
  assign run     = !ld_en;
  assign rf_we   = run && ctl.reg_write;
  assign dm_we   = run && ctl.mem_write;
  assign take_br = run && ctl.branch && alu_zero;

  // next PC
  assign pc_seq  = pc_q + 32'd4;
  assign br_tgt  = branch_dest(pc_seq, simm);
  assign pc_next = ld_en ? pc_q : (take_br ? br_tgt : pc_seq);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel) dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (dm_we)      dmem[dm_idx] <= rt_val;
  end

  assign pc_o         = pc_q;
  assign instr_o      = instr;
  assign wb_en_o      = rf_we;
  assign wb_idx_o     = wb_idx;
  assign wb_data_o    = wb_data;
  assign dmem_we_o    = dm_we;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !take_br) |=> (pc_q == $past(pc_q) + 32'd4)); // R2

  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc_q == $past(pc_q) + 32'd4 + {$past(simm[XLEN-3:0]), 2'b00})); // R8

  AST_HOLD_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> $stable(pc_q)); // R11

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, dm_we, take_br})); // R7
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, wb_data_o, dmem_addr_o, dmem_wdata_o;
  logic        wb_en_o, dmem_we_o;
  logic [4:0]  wb_idx_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o), .wb_en_o(wb_en_o),
    .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .dmem_we_o(dmem_we_o),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  // reference state
  logic [31:0] m_reg [32];
  logic [31:0] m_im [NW];
  logic [31:0] m_dm [NW];
  logic [31:0] m_pc;
  logic [31:0] prog [24];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h (pc=%h)", tag, what, act, exp, m_pc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // one cycle: drive inputs, compare against model, advance model, wait for next negedge
  task automatic cycle(bit ld, bit sel, int addr, logic [31:0] data);
    logic [31:0] w, s, a, b, res, addrb, npc;
    logic [5:0]  op, fn;
    int rs, rt, rd, dst;
    bit we, st;
    string tag;
    ld_en = ld; ld_sel = sel; ld_addr = 6'(addr); ld_data = data;
    #1;
    chk(ld ? "R11" : "R2", "pc", pc_o, m_pc);
    if (ld) begin
      chk("R11", "wb_en", {31'd0, wb_en_o}, 32'd0);
      chk("R11", "dmem_we", {31'd0, dmem_we_o}, 32'd0);
      if (sel) m_dm[addr] = data; else m_im[addr] = data;
    end else begin
      w = m_im[m_pc[7:2]];
      op = w[31:26]; fn = w[5:0];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      s = {{16{w[15]}}, w[15:0]};
      a = m_reg[rs]; b = m_reg[rt];
      we = 0; st = 0; dst = rt; res = '0; addrb = a + s;
      npc = m_pc + 32'd4; tag = "R12";
      case (op)
        6'h00: begin
          dst = rd; we = 1; tag = "R3";
          case (fn)
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: begin res = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
            default: begin we = 0; tag = "R12"; end
          endcase
        end
        6'h08: begin we = 1; res = a + s; tag = "R5"; end
        6'h0A: begin we = 1; res = ($signed(a) < $signed(s)) ? 1 : 0; tag = "R4"; end
        6'h23: begin we = 1; res = m_dm[addrb[7:2]]; tag = "R6"; end
        6'h2B: begin st = 1; tag = "R7"; end
        6'h04: begin
          tag = "R8";
          if (a == b) npc = m_pc + 32'd4 + (s << 2);
        end
        default: tag = "R12";
      endcase
      if (we && dst == 0) tag = "R9";
      else if (we && dst == rs && rs != 0) tag = "R10";
      chk(tag, "instr", instr_o, w);
      chk(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, we});
      chk(tag, "dmem_we", {31'd0, dmem_we_o}, {31'd0, st});
      if (we) begin
        chk(tag, "wb_idx", {27'd0, wb_idx_o}, 32'(dst));
        chk(tag, "wb_data", wb_data_o, res);
        if (dst != 0) m_reg[dst] = res;
      end
      if (st) begin
        chk(tag, "dmem_addr", dmem_addr_o, addrb);
        chk(tag, "dmem_wdata", dmem_wdata_o, b);
        m_dm[addrb[7:2]] = b;
      end
      m_pc = npc;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    prog[0]  = enc_i(6'h08, 0, 1, 5);        // r1 = 5
    prog[1]  = enc_i(6'h08, 0, 2, -3);       // r2 = -3
    prog[2]  = enc_r(1, 2, 3, 6'h20);        // add
    prog[3]  = enc_r(2, 1, 4, 6'h22);        // sub
    prog[4]  = enc_r(1, 2, 5, 6'h24);        // and
    prog[5]  = enc_r(1, 2, 6, 6'h25);        // or
    prog[6]  = enc_r(2, 1, 7, 6'h2A);        // slt -3<5 -> 1
    prog[7]  = enc_r(1, 2, 8, 6'h2A);        // slt 5<-3 -> 0
    prog[8]  = enc_i(6'h0A, 2, 9, -2);       // slti -3<-2 -> 1
    prog[9]  = enc_i(6'h08, 1, 0, 7);        // write to r0 ignored
    prog[10] = enc_r(0, 1, 10, 6'h20);       // r10 = r0 + r1
    prog[11] = enc_i(6'h2B, 0, 1, 8);        // sw r1 -> word 2
    prog[12] = enc_i(6'h23, 0, 11, 8);       // lw word 2
    prog[13] = enc_i(6'h08, 0, 12, 16);      // r12 = 16
    prog[14] = enc_i(6'h23, 12, 13, -4);     // lw word 3
    prog[15] = enc_i(6'h2B, 12, 4, -8);      // sw r4 -> word 2
    prog[16] = enc_i(6'h23, 0, 14, 8);       // lw word 2 sees new value
    prog[17] = enc_i(6'h04, 1, 2, 5);        // beq not taken
    prog[18] = enc_i(6'h08, 0, 15, 3);       // r15 = 3
    prog[19] = enc_i(6'h08, 15, 15, -1);     // r15 -= 1
    prog[20] = enc_i(6'h04, 15, 0, 1);       // exit loop forward
    prog[21] = enc_i(6'h04, 0, 0, -3);       // backward branch
    prog[22] = 32'hFC00_0000;                // unknown opcode
    prog[23] = enc_i(6'h04, 0, 0, -1);       // self loop

    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pc after reset", pc_o, 32'd0);

    for (int i = 0; i < NW; i++) cycle(1, 0, i, (i < 24) ? prog[i] : 32'd0);
    for (int i = 0; i < NW; i++) cycle(1, 1, i, 32'hA500_0000 + 32'(i * 3));

    for (int i = 0; i < 45; i++) cycle(0, 0, 0, '0);
    // load pulse in the middle of execution
    for (int i = 0; i < 3; i++) cycle(1, 1, 5 + i, 32'h1234_0000 + 32'(i));
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, '0);

    finish_run();
  end
endmodule